// File: doc/BRIEF.md
# Quad-Address I2C Register Target

This block is an I2C target that answers on four neighbouring 7-bit device addresses through one shared SCL/SDA front end. Every address owns a 256-byte register space and an auto-incrementing register pointer, kept apart from the other three. A controller sets the pointer with the first data byte of a write transfer. It then streams data bytes into the registers, or it reads them back in the same or a later transfer.

Each address has a fixed set of writable registers. A write to any other register is dropped, and it sets a sticky error flag. A dedicated input clears that flag. SCL and SDA are sampled through synchronisers on a system clock at least eight times faster than SCL. The target pulls SDA low through an open-drain enable and never stretches the clock.

Top module: `i2c_quad_regtarget`

## Requirements
- R1: A transfer addressed to 0x48, 0x49, 0x4A or 0x4B gets an ACK: SDA is held low through the ninth SCL pulse. Any other address gets no ACK, and SDA stays released until the next START.
- R2: The first data byte after an address byte with R/W=0 loads that address's pointer and writes no register.
- R3: Each later written byte goes to the register at the current pointer. The pointer then steps by one and wraps from 0xFF to 0x00.
- R4: Each read byte is the register at the current pointer, sent MSB first with each bit driven while SCL is low. The pointer then steps by one, with the same wrap.
- R5: The four addresses keep separate pointers and separate register contents.
- R6: Reset sets every pointer to 0x00, clears the error flag and leaves register contents unchanged.
- R7: The only writable registers are 0xC5 and 0xB4 to 0xBC at 0x49; 0x62, 0xBB, 0xBC, 0xE4, 0xE9 and 0xEE at 0x4A; 0x2F, 0x35, 0x3B, 0x44, 0x7A, 0x7D, 0x82, 0x85, 0x8E, 0x91, 0x96 and 0x99 at 0x4B; and none at 0x48. A write elsewhere leaves the register unchanged, still steps the pointer and sets `wr_err`.
- R8: `wr_err` stays set until `err_clr` is high at a clock edge. When a rejected write and a clear arrive in the same cycle, the set wins.
- R9: A repeated START keeps every pointer, so a pointer-only write followed by a repeated-START read returns the addressed register.
- R10: When the controller answers a read byte with NACK, the target releases SDA and does not drive it again until a START.
- R11: `sda_oe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line as seen at the pad |
| sda_in | input | 1 | SDA line as seen at the pad |
| err_clr | input | 1 | Clears the sticky write-error flag |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| wr_err | output | 1 | Sticky flag: a write hit a read-only register |

## Verification
A pointer that is off by one, or that belongs to the wrong address, shows up as a wrong read byte at the next read transfer of that address. That can happen many transfers after the fault. Repeated-START reads and alternating between addresses are therefore used to expose such a fault quickly.

A wrong write-permission decision shows up on `wr_err` within a few system clocks of the eighth SCL rise of the data byte. It also shows up as a changed or unchanged register on readback. A state machine that drifts out of step with the bus shows up in the very next ACK bit or read bit, as SDA driven low in the wrong SCL phase.

// File: rtl/qi2c_pkg.sv
package qi2c_pkg;

  localparam int DEV_W  = 2;   // selects one of the consecutive device addresses
  localparam int REG_W  = 8;   // register pointer width
  localparam int DATA_W = 8;   // register data width

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK,
    ST_RNEXT
  } tgt_state_t;

  // Fixed write-permission map per device slot (slot 0 = base address).
  function automatic logic reg_writable(input logic [DEV_W-1:0] dev,
                                        input logic [REG_W-1:0] r);
    logic ok;
    case (dev)
      2'd1:    ok = (r inside {[8'hB4:8'hBC], 8'hC5});
      2'd2:    ok = (r inside {8'hEE, 8'hE9, 8'hE4, 8'hBC, 8'hBB, 8'h62});
      2'd3:    ok = (r inside {8'h99, 8'h96, 8'h91, 8'h8E, 8'h85, 8'h82,
                               8'h7D, 8'h7A, 8'h44, 8'h3B, 8'h35, 8'h2F});
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/qi2c_line_sync.sv
module qi2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl,
  output logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  // STAGES synchroniser flops plus one history flop per line
  logic [STAGES:0] scl_p;
  logic [STAGES:0] sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_in};
      sda_p <= {sda_p[STAGES-1:0], sda_in};
    end
  end

  logic scl_prev, sda_prev;
  assign scl      = scl_p[STAGES-1];
  assign sda      = sda_p[STAGES-1];
  assign scl_prev = scl_p[STAGES];
  assign sda_prev = sda_p[STAGES];

  assign scl_rise  = scl & ~scl_prev;
  assign scl_fall  = ~scl & scl_prev;
  assign start_det = scl & scl_prev & sda_prev & ~sda;
  assign stop_det  = scl & scl_prev & ~sda_prev & sda;

endmodule

// File: rtl/qi2c_regbank.sv
module qi2c_regbank
  import qi2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DEV_W-1:0]  dev,
  input  logic              ptr_load,
  input  logic [REG_W-1:0]  ptr_val,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              advance,
  output logic [REG_W-1:0]  ptr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int NUM_DEV = 1 << DEV_W;
  localparam int NUM_REG = 1 << REG_W;
  localparam int DEPTH   = NUM_DEV * NUM_REG;

  logic [REG_W-1:0] ptr_q [NUM_DEV];

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst)
        ptr_q[g] <= '0;
      else if (dev == DEV_W'(g)) begin
        if (ptr_load)
          ptr_q[g] <= ptr_val;
        else if (advance)
          ptr_q[g] <= ptr_q[g] + 1'b1;
      end
    end
  end

  assign ptr = ptr_q[dev];

  // Single-port storage with registered read, suited to block RAM.
  // Contents are not touched by reset; power-up value is zero.
  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[{dev, ptr}] <= wr_data;
    rd_data <= mem[{dev, ptr}];
  end

  // R3: stepping past the top register wraps to zero
  p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (advance && !ptr_load && ptr == '1) |=> (ptr == '0));

  // R2: a pointer load takes the byte value
  p_ptr_load_r2: assert property (@(posedge clk) disable iff (rst)
    ptr_load |=> (ptr == $past(ptr_val)));

  // R7: storage is written only inside the permission map
  p_write_perm_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> reg_writable(dev, ptr));

endmodule

// File: rtl/i2c_quad_regtarget.sv
module i2c_quad_regtarget
  import qi2c_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] BASE_ADDR   = 7'h48
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  input  logic err_clr,
  output logic sda_oe,
  output logic wr_err
);

  localparam int HI_W = 7 - DEV_W;
  localparam logic [HI_W-1:0] BASE_HI = BASE_ADDR[6:DEV_W];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  qi2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl       (scl_s),
    .sda       (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tgt_state_t        st;
  logic [2:0]        bitcnt;
  logic [DATA_W-1:0] sh;
  logic [DEV_W-1:0]  dev_q;
  logic              rw_q, first_q, ack_on, oe_q, err_q;

  logic [REG_W-1:0]  cur_ptr;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] in_byte;
  logic byte_end, w_done, do_load, ptr_load, wr_en, w_reject, advance, perm;

  always_comb begin
    in_byte  = {sh[DATA_W-2:0], sda_s};
    byte_end = scl_rise && (bitcnt == 3'd7);
    w_done   = byte_end && (st == ST_WBYTE);
    do_load  = scl_fall && ((st == ST_AACK && ack_on && rw_q) || st == ST_RNEXT);
    perm     = reg_writable(dev_q, cur_ptr);
    ptr_load = w_done && first_q;
    wr_en    = w_done && !first_q && perm;
    w_reject = w_done && !first_q && !perm;
    advance  = do_load || (w_done && !first_q);
  end

  qi2c_regbank u_bank (
    .clk      (clk),
    .rst      (rst),
    .dev      (dev_q),
    .ptr_load (ptr_load),
    .ptr_val  (in_byte),
    .wr_en    (wr_en),
    .wr_data  (in_byte),
    .advance  (advance),
    .ptr      (cur_ptr),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      bitcnt  <= '0;
      sh      <= '0;
      dev_q   <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      ack_on  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_det) begin
      st     <= ST_ADDR;
      bitcnt <= '0;
      ack_on <= 1'b0;
      oe_q   <= 1'b0;
    end else if (stop_det) begin
      st     <= ST_IDLE;
      ack_on <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      if (do_load) begin
        st     <= ST_RBYTE;
        sh     <= rd_data;
        oe_q   <= ~rd_data[DATA_W-1];
        bitcnt <= '0;
        ack_on <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: if (scl_rise) begin
            sh     <= in_byte;
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == 3'd7) begin
              if (in_byte[7:DEV_W+1] == BASE_HI) begin
                dev_q <= in_byte[DEV_W:1];
                rw_q  <= in_byte[0];
                st    <= ST_AACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            if (!ack_on) begin
              oe_q   <= 1'b1;
              ack_on <= 1'b1;
            end else begin
              oe_q    <= 1'b0;
              ack_on  <= 1'b0;
              st      <= ST_WBYTE;
              first_q <= 1'b1;
              bitcnt  <= '0;
            end
          end
          ST_WBYTE: if (scl_rise) begin
            sh     <= in_byte;
            bitcnt <= bitcnt + 1'b1;
            if (byte_end) begin
              first_q <= 1'b0;
              st      <= ST_WACK;
            end
          end
          ST_WACK: if (scl_fall) begin
            if (!ack_on) begin
              oe_q   <= 1'b1;
              ack_on <= 1'b1;
            end else begin
              oe_q   <= 1'b0;
              ack_on <= 1'b0;
              st     <= ST_WBYTE;
              bitcnt <= '0;
            end
          end
          ST_RBYTE: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              oe_q <= 1'b0;
              st   <= ST_RACK;
            end else begin
              sh     <= {sh[DATA_W-2:0], 1'b0};
              oe_q   <= ~sh[DATA_W-2];
              bitcnt <= bitcnt + 1'b1;
            end
          end
          ST_RACK: if (scl_rise) begin
            st <= sda_s ? ST_IDLE : ST_RNEXT;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      err_q <= 1'b0;
    else
      err_q <= (err_q & ~err_clr) | w_reject;
  end

  assign sda_oe = oe_q;
  assign wr_err = err_q;

  // R11: the SDA driver moves only in the SCL low phase
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    (!$stable(oe_q) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

  // R10: after a STOP the line is released
  p_stop_release_r10: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !oe_q);

  // R8: the error flag holds without a clear
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (err_q && !err_clr) |=> err_q);

  // R7: a rejected write raises the flag on the next cycle
  p_reject_err_r7: assert property (@(posedge clk) disable iff (rst)
    w_reject |=> err_q);

endmodule

// File: tb/i2c_quad_regtarget_test.sv
module i2c_quad_regtarget_test;

  localparam int Q = 10;  // quarter SCL period in system clocks

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_c = 1'b1;
  logic sda_c = 1'b1;
  logic err_clr = 1'b0;
  logic sda_oe, wr_err, sda_line;

  always #2 clk = ~clk;  // 250 MHz

  assign sda_line = sda_c & ~sda_oe;

  i2c_quad_regtarget uut (
    .clk     (clk),
    .rst     (rst),
    .scl_in  (scl_c),
    .sda_in  (sda_line),
    .err_clr (err_clr),
    .sda_oe  (sda_oe),
    .wr_err  (wr_err)
  );

  int checks = 0;
  int fails  = 0;
  bit done = 0;
  bit settled = 0;
  bit m_err = 0;
  logic prev_oe = 1'b0;
  byte unsigned mmem [4][256];
  byte unsigned mptr [4];
  byte unsigned wbuf [8];

  function automatic bit m_writable(int dev, int r);
    case (dev)
      3: return r == 'h2F || r == 'h35 || r == 'h3B || r == 'h44 || r == 'h7A ||
                r == 'h7D || r == 'h82 || r == 'h85 || r == 'h8E || r == 'h91 ||
                r == 'h96 || r == 'h99;
      2: return r == 'h62 || r == 'hBB || r == 'hBC || r == 'hE4 || r == 'hE9 || r == 'hEE;
      1: return (r >= 'hB4 && r <= 'hBC) || r == 'hC5;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model: error flag (R8, R7) and
  // SDA driver timing (R11).
  always @(negedge clk) begin
    if (!rst) begin
      if (settled) begin
        checks++;
        if (wr_err !== m_err) begin
          fails++;
          $display("FAIL R8 wr_err actual=%0b expected=%0b at %0t", wr_err, m_err, $time);
        end
      end
      checks++;
      if (sda_oe !== prev_oe && scl_c) begin
        fails++;
        $display("FAIL R11 sda_oe moved with SCL high actual=%0b expected=%0b", sda_oe, prev_oe);
      end
    end
    prev_oe = sda_oe;
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_c = 1'b1; wq();
    scl_c = 1'b1; wq();
    sda_c = 1'b0; wq();
    scl_c = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_c = 1'b0; wq();
    scl_c = 1'b1; wq();
    sda_c = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_c = b[i]; wq();
      scl_c = 1'b1; wq(); wq();
      scl_c = 1'b0; wq();
    end
    sda_c = 1'b1; wq();
    scl_c = 1'b1; wq();
    ack = sda_line;
    wq();
    scl_c = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    sda_c = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl_c = 1'b1; wq();
      b[i] = sda_line;
      wq();
      scl_c = 1'b0; wq();
    end
    sda_c = nack; wq();
    scl_c = 1'b1; wq(); wq();
    scl_c = 1'b0;
    sda_c = 1'b1; wq();
  endtask

  // Write transfer: pointer byte then n data bytes from wbuf.
  task automatic wr_txn(int dev, int p, int n, bit do_stop);
    logic ack;
    i2c_start();
    send_byte({7'(7'h48 + dev), 1'b0}, ack);
    chk("R1 ack on own address", ack, 0);
    settled = 0;
    send_byte(8'(p), ack);
    mptr[dev] = 8'(p);
    settled = 1;
    for (int i = 0; i < n; i++) begin
      settled = 0;
      send_byte(wbuf[i], ack);
      if (m_writable(dev, mptr[dev])) mmem[dev][mptr[dev]] = wbuf[i];
      else m_err = 1;
      mptr[dev] = mptr[dev] + 8'd1;
      settled = 1;
    end
    if (do_stop) i2c_stop();
  endtask

  // Read transfer of n bytes, last one NACKed (R4, R10).
  task automatic rd_txn(int dev, int n, string req);
    logic ack;
    logic [7:0] b;
    i2c_start();
    send_byte({7'(7'h48 + dev), 1'b1}, ack);
    chk("R1 ack on read address", ack, 0);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, b);
      chk({req, " R4 read byte"}, b, mmem[dev][mptr[dev]]);
      mptr[dev] = mptr[dev] + 8'd1;
    end
    wq();
    chk("R10 SDA released after NACK", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic probe_addr(logic [6:0] a, int exp_ack);
    logic ack;
    i2c_start();
    send_byte({a, 1'b0}, ack);
    chk("R1 address response", ack, exp_ack);
    wq();
    chk("R1 SDA idle after address", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic do_reset();
    settled = 0;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    for (int d = 0; d < 4; d++) mptr[d] = 8'd0;
    m_err = 0;
    repeat (3) @(negedge clk);
    settled = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < 4; d++) begin
      mptr[d] = 0;
      for (int r = 0; r < 256; r++) mmem[d][r] = 0;
    end
    do_reset();
    chk("R6 wr_err after reset", wr_err, 0);
    chk("R6 sda_oe after reset", sda_oe, 0);

    // R1: the four own addresses answer, neighbours do not
    for (int d = 0; d < 4; d++) probe_addr(7'(7'h48 + d), 0);
    probe_addr(7'h47, 1);
    probe_addr(7'h4C, 1);

    // R3: burst write at 0x49, then R9 repeated-START readback
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_txn(1, 'hB4, 3, 1);
    wr_txn(1, 'hB4, 0, 0);
    rd_txn(1, 4, "R9 R3");

    // R5: separate pointers
    wbuf[0] = 8'h99;
    wr_txn(1, 'hB8, 1, 1);
    wbuf[0] = 8'h3C;
    wr_txn(3, 'h35, 1, 1);
    wr_txn(1, 'hB8, 0, 1);
    wr_txn(3, 'h35, 0, 1);
    rd_txn(1, 1, "R5 dev49");
    rd_txn(3, 1, "R5 dev4B");

    // R2: a pointer-only write stores nothing
    wbuf[0] = 8'h5A;
    wr_txn(3, 'h2F, 1, 1);
    wr_txn(3, 'h2F, 0, 1);
    chk("R2 no error from pointer byte", wr_err, 0);
    rd_txn(3, 1, "R2");

    // R7: read-only target sets the error, neighbour accepts
    wbuf[0] = 8'h77; wbuf[1] = 8'h88;
    wr_txn(2, 'h61, 2, 1);
    chk("R7 error on read-only register", wr_err, 1);
    wr_txn(2, 'h61, 0, 0);
    rd_txn(2, 2, "R7 readback");
    wbuf[0] = 8'h33;
    wr_txn(0, 'h10, 1, 1);
    wr_txn(0, 'h10, 0, 0);
    rd_txn(0, 1, "R7 base address read-only");

    // R8: sticky until cleared
    chk("R8 flag held", wr_err, 1);
    settled = 0;
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    m_err = 0;
    repeat (3) @(negedge clk);
    settled = 1;
    chk("R8 flag cleared", wr_err, 0);

    // R3: wrap from 0xFF to 0x00, for reads and for rejected writes
    wbuf[0] = 8'h01; wbuf[1] = 8'h02;
    wr_txn(3, 'hFF, 2, 1);
    chk("R3 wrap writes rejected", wr_err, 1);
    wr_txn(2, 'hFF, 0, 0);
    rd_txn(2, 3, "R3 wrap read");
    wbuf[0] = 8'hA1;
    wr_txn(1, 'hC5, 1, 0);
    wr_txn(1, 'hC5, 0, 0);
    rd_txn(1, 1, "R3 single write");

    // R6: reset returns pointers to zero and keeps contents
    wr_txn(3, 'h2F, 0, 1);
    do_reset();
    chk("R6 flag cleared by reset", wr_err, 0);
    rd_txn(3, 1, "R6 pointer zero");
    rd_txn(1, 1, "R6 pointer zero dev49");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule